// File: doc/BRIEF.md
# Li-ion charge cycle controller

This block sequences one linear lithium-ion charger. Comparator flags from the analog side tell it where the battery stands: above the short-circuit level, above the low-voltage level, at the regulation voltage, below the recharge level, and below the termination current. Further flags report the pack temperature window, an active current-reducing loop (die thermal, load sharing or sagging input), thermal shutdown and battery supplement. From these flags and the enable controls it picks one phase: idle, short test, precharge, fast charge, constant voltage, done, one of two battery-presence probes, or fault. The analog loops act on that phase.

Two safety timers guard the precharge and fast-charge spans. They advance by a weight taken from the measured charge-current fraction, so a reduced charge rate stretches the allowed time in proportion. Either timer expiring latches a fault, and the status output then blinks. The status output is sticky. It goes low when a new cycle passes its short test and is released at termination. It does not report later top-off recharges.

Top module: `liion_cycle_ctrl`

## Requirements
- R1: While `ce_n` is high, `pwr_ok` is low or `suspend` is high, `phase` is 0 (idle), `chg_on` is 0 and `chg_n` is 1. Both timers are cleared, so a later cycle gets its full precharge budget again.
- R2: When enabled, the block goes from idle to phase 1 (short test) and stays there while `bat_above_short` is 0. When that flag is 1, the next phase is 2 (precharge) if `bat_above_lowv` is 0 and 3 (fast charge) otherwise. `chg_n` goes to 0 in that same cycle.
- R3: Precharge moves to fast charge when `bat_above_lowv` is 1. Fast charge moves to phase 4 (constant voltage) when `bat_at_reg` is 1.
- R4: In constant voltage, `cur_below_term` moves the block to phase 5 (done) and sets `chg_n` to 1. This happens only while `loop_active`, `supplement` and `therm_shdn` are all 0 and `temp_ok` is 1.
- R5: The precharge timer expires after PRE_TICKS time units spent in precharge. The fast-charge timer covers fast charge and constant voltage together and expires after 10*PRE_TICKS units. Either expiry moves the block to phase 8 (fault) in the cycle after the limit is reached.
- R6: Each clock a timer runs, it adds a weight to a 16-step accumulator, and every carry is one time unit. `rate_code` 0 means weight 16 (full rate). Any other code c means weight c, so code 8 counts at exactly half speed.
- R7: While `temp_ok` is 0 or `therm_shdn` is 1, `chg_on` is 0 and the charge phase and both timers hold. `chg_n` keeps its value. Counting resumes from the held value once the condition clears.
- R8: In fault, `chg_n` is 0 for the first BLINK_HALF cycles and then toggles every BLINK_HALF cycles. Fault is left only through the idle condition of R1.
- R9: In done, with `td` 0, `bat_below_rch` starts phase 6 (detect current) for DET_CYCLES cycles. If `bat_above_lowv` is then 1, the block recharges in fast charge with `chg_n` kept at 1. Otherwise it spends DET_CYCLES cycles in phase 7 (precharge probe). After that, `bat_below_rch` at 1 starts a new cycle at the short test, which sets `chg_n` to 0 again once the test passes. With `bat_below_rch` at 0 the block repeats phase 6.
- R10: With `td` high, constant voltage never terminates and no timer runs. `cur_below_term` sets `chg_n` to 1, which then stays 1 until the idle condition of R1 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Input source inside its valid window |
| suspend | input | 1 | Input suspend selected |
| ce_n | input | 1 | Charge enable, active low |
| td | input | 1 | Termination disable |
| bat_above_short | input | 1 | Battery above short-circuit level |
| bat_above_lowv | input | 1 | Battery above low-voltage level |
| bat_at_reg | input | 1 | Battery reached regulation voltage |
| bat_below_rch | input | 1 | Battery below recharge level |
| cur_below_term | input | 1 | Charge current below termination level |
| temp_ok | input | 1 | Pack temperature inside its window |
| loop_active | input | 1 | A current-reducing regulation loop is active |
| therm_shdn | input | 1 | Die thermal shutdown |
| supplement | input | 1 | Battery supplements the system load |
| rate_code | input | 4 | Charge-current fraction code (0 = full, else code/16) |
| phase | output | 4 | Current phase code |
| chg_on | output | 1 | Charge current applied |
| chg_n | output | 1 | Status, 0 = indicating, 1 = released |

## Verification
The bench probes the exact cycle in which each timer fires, at both full and half rate. An off-by-one in the accumulator or the limit compare shows up as a fault one cycle early or late. Scaling that ignored the rate code shows up as a fault at the full-rate cycle. A temperature pause in mid-precharge must push the fault back by exactly the paused span. A design that kept counting would fault early, and one that reset the timer would fault late. On the recharge path the status output must stay released, and a missing-battery probe must loop back to detection. A design that re-indicated recharges, or that restarted without a battery, would show the wrong status or phase there. Further checks confirm that termination disable keeps the charger in constant voltage past the fast-charge limit while still releasing the status, and that fault survives input changes until the block is disabled.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [3:0] {
    PH_OFF   = 4'd0,
    PH_SHORT = 4'd1,
    PH_PRE   = 4'd2,
    PH_FAST  = 4'd3,
    PH_CV    = 4'd4,
    PH_DONE  = 4'd5,
    PH_DETA  = 4'd6,
    PH_DETB  = 4'd7,
    PH_FAULT = 4'd8
  } phase_e;

  // Accumulator weight per clock: code 0 is full rate (16/16), else code/16.
  function automatic logic [4:0] rate_weight(input logic [3:0] code);
    return (code == 4'd0) ? 5'd16 : {1'b0, code};
  endfunction

  // Termination may be taken only with no loop cutting the charge rate.
  function automatic logic term_allowed(input logic below_term, input logic loop_on,
                                        input logic shdn, input logic supp,
                                        input logic temp_in);
    return below_term && !loop_on && !shdn && !supp && temp_in;
  endfunction

endpackage

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
  import chg_seq_pkg::*;
#(
  parameter int PRE_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic       sel_fast,
  input  logic [3:0] rate_code,
  output logic       expired
);
  localparam int FAST_TICKS = 10 * PRE_TICKS;
  localparam int CW = $clog2(FAST_TICKS + 1);

  logic [3:0]    acc_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] limit;
  logic [4:0]    sum;
  logic          unit_tick;

  assign limit     = sel_fast ? CW'(FAST_TICKS) : CW'(PRE_TICKS);
  assign sum       = {1'b0, acc_q} + rate_weight(rate_code);
  assign unit_tick = sum[4];
  assign expired   = (count_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      count_q <= '0;
    end else if (clr) begin
      acc_q   <= '0;
      count_q <= '0;
    end else if (run) begin
      acc_q <= sum[3:0];
      if (unit_tick && (count_q < limit)) count_q <= count_q + CW'(1);
    end
  end

  // R7: a paused timer keeps its value
  a_r7_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count_q));

  // R6: at full rate every running clock is one unit
  a_r6_full_rate_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && rate_code == 4'd0 && count_q < limit) |=> (count_q == $past(count_q) + CW'(1)));

endmodule

// File: rtl/chg_blink.sv
module chg_blink #(
  parameter int HALF = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic blink_q
);
  localparam int BW = $clog2(HALF + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
    end else if (!en) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
    end else if (cnt_q == BW'(HALF - 1)) begin
      cnt_q   <= '0;
      blink_q <= ~blink_q;
    end else begin
      cnt_q <= cnt_q + BW'(1);
    end
  end

  // R8: blink starts from the low half every time fault is entered
  a_r8_blink_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !blink_q);

endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm
  import chg_seq_pkg::*;
#(
  parameter int DET_CYCLES = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   td,
  input  logic   bat_above_short,
  input  logic   bat_above_lowv,
  input  logic   bat_at_reg,
  input  logic   bat_below_rch,
  input  logic   cur_below_term,
  input  logic   temp_ok,
  input  logic   loop_active,
  input  logic   therm_shdn,
  input  logic   supplement,
  input  logic   tmr_expired,
  output phase_e phase_q,
  output logic   chg_low_q,
  output logic   tmr_clr,
  output logic   paused
);
  localparam int DW = $clog2(DET_CYCLES + 1);

  phase_e        phase_d;
  logic          chg_low_d;
  logic [DW-1:0] det_cnt_q;
  logic          det_done;
  logic          term_ok;
  logic          timeout;

  assign paused   = !temp_ok || therm_shdn;
  assign det_done = (det_cnt_q == DW'(DET_CYCLES - 1));
  assign term_ok  = term_allowed(cur_below_term, loop_active, therm_shdn, supplement, temp_ok);
  assign timeout  = tmr_expired && !td;

  always_comb begin
    phase_d   = phase_q;
    chg_low_d = chg_low_q;
    if (!enable) begin
      phase_d   = PH_OFF;
      chg_low_d = 1'b0;
    end else begin
      case (phase_q)
        PH_OFF:   phase_d = PH_SHORT;
        PH_SHORT: if (bat_above_short) begin
                    phase_d   = bat_above_lowv ? PH_FAST : PH_PRE;
                    chg_low_d = 1'b1;
                  end
        PH_PRE:   if (!paused) begin
                    if (bat_above_lowv) phase_d = PH_FAST;
                    else if (timeout)   phase_d = PH_FAULT;
                  end
        PH_FAST:  if (!paused) begin
                    if (timeout)         phase_d = PH_FAULT;
                    else if (bat_at_reg) phase_d = PH_CV;
                  end
        PH_CV:    if (td) begin
                    if (cur_below_term) chg_low_d = 1'b0;
                  end else if (!paused) begin
                    if (timeout) phase_d = PH_FAULT;
                    else if (term_ok) begin
                      phase_d   = PH_DONE;
                      chg_low_d = 1'b0;
                    end
                  end
        PH_DONE:  if (!td && bat_below_rch) phase_d = PH_DETA;
        PH_DETA:  if (det_done) phase_d = bat_above_lowv ? PH_FAST : PH_DETB;
        PH_DETB:  if (det_done) phase_d = bat_below_rch ? PH_SHORT : PH_DETA;
        PH_FAULT: phase_d = PH_FAULT;
        default:  phase_d = PH_OFF;
      endcase
    end
  end

  assign tmr_clr = !enable ||
                   ((phase_d != phase_q) && (phase_d == PH_PRE || phase_d == PH_FAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_OFF;
      chg_low_q <= 1'b0;
      det_cnt_q <= '0;
    end else begin
      phase_q   <= phase_d;
      chg_low_q <= chg_low_d;
      det_cnt_q <= (phase_d != phase_q) ? '0 : det_cnt_q + DW'(1);
    end
  end

  // R1: disabling always returns to idle
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase_q == PH_OFF && !chg_low_q));

  // R2: no charging before the short test passes
  a_r2_hold_short: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SHORT && !bat_above_short) |=> (phase_q == PH_SHORT || phase_q == PH_OFF));

  // R4: an inhibited constant-voltage phase never terminates
  a_r4_term_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CV && (loop_active || supplement || therm_shdn || !temp_ok)) |=> phase_q != PH_DONE);

  // R8: fault is left only through idle
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FAULT) |=> (phase_q == PH_FAULT || phase_q == PH_OFF));

  // R9: detection never indicates charging
  a_r9_detect_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DETA || phase_q == PH_DETB) |-> !chg_low_q);

  // R10: termination disabled keeps constant voltage
  a_r10_td_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (td && phase_q == PH_CV) |=> phase_q != PH_DONE);

endmodule

// File: rtl/liion_cycle_ctrl.sv
module liion_cycle_ctrl
  import chg_seq_pkg::*;
#(
  parameter int PRE_TICKS  = 1000,
  parameter int DET_CYCLES = 64,
  parameter int BLINK_HALF = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       suspend,
  input  logic       ce_n,
  input  logic       td,
  input  logic       bat_above_short,
  input  logic       bat_above_lowv,
  input  logic       bat_at_reg,
  input  logic       bat_below_rch,
  input  logic       cur_below_term,
  input  logic       temp_ok,
  input  logic       loop_active,
  input  logic       therm_shdn,
  input  logic       supplement,
  input  logic [3:0] rate_code,
  output logic [3:0] phase,
  output logic       chg_on,
  output logic       chg_n
);
  phase_e phase_q;
  logic   enable, chg_low_q, tmr_clr, paused, tmr_run, tmr_expired, in_fault, blink_q;
  logic   in_charge;

  assign enable    = pwr_ok && !suspend && !ce_n;
  assign in_charge = (phase_q == PH_PRE) || (phase_q == PH_FAST) || (phase_q == PH_CV);
  assign tmr_run   = in_charge && !td && !paused;
  assign in_fault  = (phase_q == PH_FAULT);

  chg_phase_fsm #(.DET_CYCLES(DET_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .td(td),
    .bat_above_short(bat_above_short), .bat_above_lowv(bat_above_lowv),
    .bat_at_reg(bat_at_reg), .bat_below_rch(bat_below_rch),
    .cur_below_term(cur_below_term), .temp_ok(temp_ok),
    .loop_active(loop_active), .therm_shdn(therm_shdn), .supplement(supplement),
    .tmr_expired(tmr_expired), .phase_q(phase_q), .chg_low_q(chg_low_q),
    .tmr_clr(tmr_clr), .paused(paused)
  );

  chg_safety_timer #(.PRE_TICKS(PRE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .sel_fast(phase_q != PH_PRE), .rate_code(rate_code), .expired(tmr_expired)
  );

  chg_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .en(in_fault), .blink_q(blink_q)
  );

  assign phase  = phase_q;
  assign chg_on = in_charge && !paused;
  assign chg_n  = in_fault ? blink_q : !chg_low_q;

  // R7: no charge current while paused
  a_r7_no_current_paused: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !chg_on);

endmodule

// File: tb/liion_cycle_ctrl_test.sv
`timescale 1ns/100ps
module liion_cycle_ctrl_test;
  localparam int P = 6;
  localparam int DET = 4;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1, suspend = 1'b0, ce_n = 1'b1, td = 1'b0;
  logic bat_above_short = 1'b0, bat_above_lowv = 1'b0, bat_at_reg = 1'b0;
  logic bat_below_rch = 1'b0, cur_below_term = 1'b0, temp_ok = 1'b1;
  logic loop_active = 1'b0, therm_shdn = 1'b0, supplement = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic [3:0] phase;
  logic chg_on, chg_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  liion_cycle_ctrl #(.PRE_TICKS(P), .DET_CYCLES(DET), .BLINK_HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .suspend(suspend), .ce_n(ce_n), .td(td),
    .bat_above_short(bat_above_short), .bat_above_lowv(bat_above_lowv),
    .bat_at_reg(bat_at_reg), .bat_below_rch(bat_below_rch),
    .cur_below_term(cur_below_term), .temp_ok(temp_ok), .loop_active(loop_active),
    .therm_shdn(therm_shdn), .supplement(supplement), .rate_code(rate_code),
    .phase(phase), .chg_on(chg_on), .chg_n(chg_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_all();
    ce_n = 1'b1; tick(2);
    td = 0; bat_above_short = 1; bat_above_lowv = 0; bat_at_reg = 0; bat_below_rch = 0;
    cur_below_term = 0; temp_ok = 1; loop_active = 0; therm_shdn = 0; supplement = 0;
    rate_code = 4'd0; suspend = 0; pwr_ok = 1;
  endtask

  task automatic start_to_pre();
    ce_n = 1'b0; tick(1); tick(1);
  endtask

  task automatic reach_done();
    idle_all(); start_to_pre();
    bat_above_lowv = 1; tick(1);
    bat_at_reg = 1; tick(1);
    cur_below_term = 1; tick(1);
    cur_below_term = 0; bat_at_reg = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset phase", phase, 0);
    chk("R1 reset chg_n", chg_n, 1);
    chk("R1 reset chg_on", chg_on, 0);
  endtask

  task automatic t_normal();
    idle_all(); bat_above_short = 0;
    ce_n = 0; tick(1);
    chk("R2 short entered", phase, 1);
    tick(3);
    chk("R2 short held", phase, 1);
    chk("R2 chg_n before pass", chg_n, 1);
    bat_above_short = 1; tick(1);
    chk("R2 precharge", phase, 2);
    chk("R2 chg_n low", chg_n, 0);
    chk("R2 chg_on", chg_on, 1);
    bat_above_lowv = 1; tick(1);
    chk("R3 fast", phase, 3);
    bat_at_reg = 1; tick(1);
    chk("R3 cv", phase, 4);
    cur_below_term = 1; loop_active = 1; tick(2);
    chk("R4 loop inhibits", phase, 4);
    loop_active = 0; supplement = 1; tick(2);
    chk("R4 supplement inhibits", phase, 4);
    supplement = 0; tick(1);
    chk("R4 done", phase, 5);
    chk("R4 chg released", chg_n, 1);
  endtask

  task automatic t_pre_timeout();
    idle_all(); start_to_pre();
    chk("R5 pre start", phase, 2);
    tick(P - 1);
    chk("R5 pre before limit", phase, 2);
    tick(2);
    chk("R5 pre timeout fault", phase, 8);
    chk("R8 blink low first", chg_n, 0);
    tick(H - 1);
    chk("R8 blink still low", chg_n, 0);
    tick(1);
    chk("R8 blink high", chg_n, 1);
    tick(H);
    chk("R8 blink low again", chg_n, 0);
    bat_above_lowv = 1; tick(3);
    chk("R8 fault sticky", phase, 8);
    ce_n = 1; tick(1);
    chk("R8 fault cleared", phase, 0);
    chk("R1 chg_n idle", chg_n, 1);
  endtask

  task automatic t_half_rate();
    idle_all(); rate_code = 4'd8; start_to_pre();
    tick(2 * P);
    chk("R6 half rate still pre", phase, 2);
    tick(1);
    chk("R6 half rate fault", phase, 8);
  endtask

  task automatic t_suspend_resets();
    idle_all(); start_to_pre();
    tick(P - 2);
    suspend = 1; tick(1);
    chk("R1 suspend idle", phase, 0);
    suspend = 0; tick(2);
    chk("R1 restart pre", phase, 2);
    tick(P - 1);
    chk("R1 timer was reset", phase, 2);
    tick(2);
    chk("R1 fresh timeout", phase, 8);
  endtask

  task automatic t_temp_pause();
    idle_all(); start_to_pre();
    tick(2);
    temp_ok = 0; tick(10);
    chk("R7 phase held", phase, 2);
    chk("R7 no current", chg_on, 0);
    chk("R7 chg_n stays low", chg_n, 0);
    temp_ok = 1;
    tick(P - 2);
    chk("R7 resumed not expired", phase, 2);
    tick(1);
    chk("R7 fault after resume", phase, 8);
    idle_all(); start_to_pre();
    therm_shdn = 1; tick(1);
    chk("R7 shutdown no current", chg_on, 0);
  endtask

  task automatic t_fast_timeout();
    idle_all(); bat_above_lowv = 1; ce_n = 0; tick(2);
    chk("R5 fast start", phase, 3);
    bat_at_reg = 1;
    tick(10 * P);
    chk("R5 cv before fast limit", phase, 4);
    tick(1);
    chk("R5 fast timeout fault", phase, 8);
  endtask

  task automatic t_recharge();
    reach_done();
    chk("R9 in done", phase, 5);
    bat_below_rch = 1; tick(1);
    chk("R9 detect", phase, 6);
    tick(DET - 1);
    chk("R9 detect held", phase, 6);
    tick(1);
    chk("R9 recharge fast", phase, 3);
    chk("R9 recharge silent", chg_n, 1);
    chk("R9 recharge current", chg_on, 1);
  endtask

  task automatic t_missing();
    reach_done();
    bat_above_lowv = 0; bat_below_rch = 1; tick(1);
    chk("R9 detect start", phase, 6);
    tick(DET);
    chk("R9 probe", phase, 7);
    bat_below_rch = 0; tick(DET);
    chk("R9 missing repeats", phase, 6);
    bat_below_rch = 1; tick(DET);
    chk("R9 probe again", phase, 7);
    tick(DET);
    chk("R9 new cycle short", phase, 1);
    chk("R9 new cycle chg_n", chg_n, 1);
    tick(1);
    chk("R9 new cycle indicated", chg_n, 0);
  endtask

  task automatic t_td();
    idle_all(); td = 1; start_to_pre();
    bat_above_lowv = 1; tick(1);
    bat_at_reg = 1; tick(1);
    tick(10 * P + 10);
    chk("R10 no timeout", phase, 4);
    chk("R10 chg_n low", chg_n, 0);
    cur_below_term = 1; tick(1);
    chk("R10 stays cv", phase, 4);
    chk("R10 released", chg_n, 1);
    cur_below_term = 0; tick(2);
    chk("R10 release sticky", chg_n, 1);
    ce_n = 1; tick(1);
    chk("R10 toggle idle", phase, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_normal();
    t_pre_timeout();
    t_half_rate();
    t_suspend_resets();
    t_temp_pause();
    t_fast_timeout();
    t_recharge();
    t_missing();
    t_td();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule